// File: doc/BRIEF.md
# Indexed Block-Transfer Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers and presents them to the rest of the chip as one parallel bus. The master reaches the bank with an indexed block protocol. In a write, the master sends the device address, a starting register index, a byte count and then data bytes. In a read, the master sends the address and an index, then a repeated START and the read address. The slave answers with the stored byte count first and the register contents after it.

SCL and SDA are sampled by the system clock through a synchronizer. The slave detects START, repeated START and STOP from the sampled lines, and pulls SDA low through an open-drain output enable. It pulls SDA low to acknowledge a byte and to send zero bits. It changes SDA only while SCL is low. The bus speed is at most 100 kbit/s, so the system clock sees every bus phase many times.

Top module: `blkreg_slave`

## Requirements
- R1: After reset, register i holds (92 + 37*i) mod 256, and the count register holds NUM_REGS. Register i appears on `regs_o` bits [8i+7:8i].
- R2: The device address is 7'h6A. The byte after START is acknowledged only when it is 0xD4 (write) or 0xD5 (read). Any other address byte gets no acknowledge, and every later byte is ignored and left unacknowledged until the next START.
- R3: In a write, the slave acknowledges the index, the count and each data byte. Data byte k lands in register N+k, where N is the index.
- R4: A write keeps loading data bytes until STOP, including bytes beyond the count that was sent.
- R5: A starting index of NUM_REGS or more is reduced modulo NUM_REGS. Stepping past the last register continues at register 0, for both writes and reads.
- R6: After a repeated START and 0xD5, the slave sends the count register value first. It then sends registers N, N+1, and so on, MSB first, for as long as the master acknowledges.
- R7: A master NACK ends the read. The slave leaves SDA released until the next START.
- R8: A STOP in the middle of a byte discards the partial byte, and every byte completed before it stays written.
- R9: SDA (`sda_oe_o`, 1 = pull low) changes only while SCL is low. The slave releases it during the acknowledge clock of every byte it sends.
- R10: Each write's count byte is stored in the count register, and later reads return that value.
- R11: A START seen in the middle of a byte aborts that byte and restarts address decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NUM_REGS*8 | Register bank, register i at bits [8i+7:8i] |

## Verification
Writes are tried with an in-range index, with an index on the last register, and with an out-of-range index. These separate plain sequencing from the two kinds of wrap. A write that sends more data bytes than its count shows whether loading stops at the count or at STOP. Reads with different indices and after different writes show whether the count byte comes from the latest write or from the reset value, and whether data starts at the requested index. A foreign address, a STOP in mid-byte and a START in mid-byte each test a different path out of an unfinished transfer, and the registers are read back afterwards to show which bytes were kept.

// File: rtl/blkreg_pkg.sv
package blkreg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK_OUT,
    PH_TX,
    PH_ACK_IN
  } phase_e;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_INDEX,
    BY_COUNT,
    BY_DATA
  } byte_role_e;

  // Starting index folded into the bank.
  function automatic int unsigned wrap_index(int unsigned v, int unsigned n);
    return v % n;
  endfunction

  // Next register after v, back to 0 past the last one.
  function automatic int unsigned step_index(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // Power-on contents of register i.
  function automatic logic [7:0] reset_value(int unsigned i);
    int unsigned t;
    t = i * 37 + 92;
    return t[7:0];
  endfunction

  function automatic logic addr_hit(logic [7:0] b, logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

endpackage

// File: rtl/blkreg_linesync.sv
module blkreg_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic scl_prev;
  logic sda_prev;
  logic scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
      scl_prev <= scl_sh[STAGES-1];
      sda_prev <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/blkreg_bank.sv
module blkreg_bank
  import blkreg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      idx,
  input  logic [7:0]            wr_data,
  input  logic                  cnt_we,
  output logic [7:0]            rd_byte,
  output logic [7:0]            cnt_q,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  logic [7:0]          bank_q [NUM_REGS];
  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    assign hit[g]             = wr_en && (idx == IDX_W'(g));
    assign regs_flat[g*8 +: 8] = bank_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < NUM_REGS; i++) bank_q[i] <= reset_value(i);
      cnt_q <= 8'(NUM_REGS);
    end else begin
      for (int unsigned i = 0; i < NUM_REGS; i++) begin
        if (hit[i]) bank_q[i] <= wr_data;
      end
      if (cnt_we) cnt_q <= wr_data;
    end
  end

  assign rd_byte = bank_q[idx];

endmodule

// File: rtl/blkreg_proto.sv
module blkreg_proto
  import blkreg_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_lvl,
  input  logic [7:0]       rd_byte,
  input  logic [7:0]       cnt_byte,
  output logic             sda_oe,
  output logic [IDX_W-1:0] ptr,
  output logic             wr_en,
  output logic             cnt_we,
  output logic [7:0]       wr_data
);

  phase_e     phase;
  byte_role_e role;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       rd_mode;
  logic       ack_go;
  logic       acked;

  logic [7:0]       rx_byte;
  logic             byte_end;
  logic [IDX_W-1:0] next_ptr;
  logic [IDX_W-1:0] index_ptr;
  byte_role_e       next_role;

  assign rx_byte   = {shreg[6:0], sda_lvl};
  assign byte_end  = (phase == PH_RX) && scl_rise && (bit_cnt == 4'd7);
  assign next_ptr  = IDX_W'(step_index(32'(ptr), NUM_REGS));
  assign index_ptr = IDX_W'(wrap_index(32'(rx_byte), NUM_REGS));
  assign wr_en     = byte_end && (role == BY_DATA);
  assign cnt_we    = byte_end && (role == BY_COUNT);
  assign wr_data   = rx_byte;

  always_comb begin
    unique case (role)
      BY_ADDR:  next_role = BY_INDEX;
      BY_INDEX: next_role = BY_COUNT;
      default:  next_role = BY_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      role    <= BY_ADDR;
      bit_cnt <= '0;
      shreg   <= '0;
      sda_oe  <= 1'b0;
      rd_mode <= 1'b0;
      ack_go  <= 1'b0;
      acked   <= 1'b0;
      ptr     <= '0;
    end else if (start_det) begin
      phase   <= PH_RX;
      role    <= BY_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
      rd_mode <= 1'b0;
    end else if (stop_det) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (byte_end) begin
            unique case (role)
              BY_ADDR: begin
                ack_go  <= addr_hit(rx_byte, DEV_ADDR);
                rd_mode <= rx_byte[0];
              end
              BY_INDEX: begin
                ack_go <= 1'b1;
                ptr    <= index_ptr;
              end
              BY_COUNT: ack_go <= 1'b1;
              BY_DATA: begin
                ack_go <= 1'b1;
                ptr    <= next_ptr;
              end
            endcase
          end
          if (scl_fall && bit_cnt == 4'd8) begin
            if (ack_go) begin
              sda_oe <= 1'b1;
              phase  <= PH_ACK_OUT;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_ACK_OUT: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (role == BY_ADDR && rd_mode) begin
              phase  <= PH_TX;
              sda_oe <= ~cnt_byte[7];
              shreg  <= {cnt_byte[6:0], 1'b0};
            end else begin
              phase  <= PH_RX;
              sda_oe <= 1'b0;
              role   <= next_role;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe <= 1'b0;
              phase  <= PH_ACK_IN;
            end else begin
              sda_oe <= ~shreg[7];
              shreg  <= {shreg[6:0], 1'b0};
            end
          end
        end
        PH_ACK_IN: begin
          if (scl_rise) acked <= ~sda_lvl;
          if (scl_fall) begin
            if (acked) begin
              bit_cnt <= '0;
              sda_oe  <= ~rd_byte[7];
              shreg   <= {rd_byte[6:0], 1'b0};
              ptr     <= next_ptr;
              phase   <= PH_TX;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/blkreg_slave.sv
module blkreg_slave
  import blkreg_pkg::*;
#(
  parameter int         NUM_REGS    = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         SYNC_STAGES = 2,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  // Named internal events, visible to the bound checker.
  logic             ev_sda_lvl;
  logic             ev_scl_rise;
  logic             ev_scl_fall;
  logic             ev_start;
  logic             ev_stop;
  logic             ev_wr_en;
  logic             ev_cnt_we;
  logic [7:0]       ev_wr_data;
  logic [IDX_W-1:0] cur_ptr;
  logic [7:0]       rd_byte;
  logic [7:0]       cnt_q;

  blkreg_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (ev_sda_lvl),
    .scl_rise  (ev_scl_rise),
    .scl_fall  (ev_scl_fall),
    .start_det (ev_start),
    .stop_det  (ev_stop)
  );

  blkreg_proto #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (ev_scl_rise),
    .scl_fall  (ev_scl_fall),
    .start_det (ev_start),
    .stop_det  (ev_stop),
    .sda_lvl   (ev_sda_lvl),
    .rd_byte   (rd_byte),
    .cnt_byte  (cnt_q),
    .sda_oe    (sda_oe_o),
    .ptr       (cur_ptr),
    .wr_en     (ev_wr_en),
    .cnt_we    (ev_cnt_we),
    .wr_data   (ev_wr_data)
  );

  blkreg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ev_wr_en),
    .idx       (cur_ptr),
    .wr_data   (ev_wr_data),
    .cnt_we    (ev_cnt_we),
    .rd_byte   (rd_byte),
    .cnt_q     (cnt_q),
    .regs_flat (regs_o)
  );

endmodule

// File: rtl/blkreg_slave_chk.sv
module blkreg_slave_chk
  import blkreg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic                  ev_start,
  input logic                  ev_stop,
  input logic                  ev_wr_en,
  input logic                  ev_cnt_we,
  input logic [7:0]            ev_wr_data,
  input logic [IDX_W-1:0]      cur_ptr,
  input logic [7:0]            cnt_q,
  input logic [NUM_REGS*8-1:0] regs_o
);

  logic [IDX_W-1:0] last_idx;
  logic [7:0]       landed;
  logic             rst_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx <= '0;
      rst_seen <= 1'b0;
    end else begin
      last_idx <= cur_ptr;
      rst_seen <= 1'b1;
    end
  end

  always_comb landed = regs_o[32'(last_idx)*8 +: 8];

  // R1: first clock after reset shows the defaults
  always_ff @(posedge clk) begin
    if (rst_n && !rst_seen) begin
      a_r1_count_default: assert (cnt_q == 8'(NUM_REGS));
      for (int unsigned i = 0; i < NUM_REGS; i++) begin
        a_r1_reg_default: assert (regs_o[i*8 +: 8] == reset_value(i));
      end
    end
  end

  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_en |=> landed == $past(ev_wr_data));

  a_r10_count_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cnt_we |=> cnt_q == $past(ev_wr_data));

  a_r7_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe_o);

  a_r11_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe_o);

endmodule

bind blkreg_slave blkreg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .ev_start   (ev_start),
  .ev_stop    (ev_stop),
  .ev_wr_en   (ev_wr_en),
  .ev_cnt_we  (ev_cnt_we),
  .ev_wr_data (ev_wr_data),
  .cur_ptr    (cur_ptr),
  .cnt_q      (cnt_q),
  .regs_o     (regs_o)
);

// File: tb/blkreg_slave_test.sv
module blkreg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  wire  sda_oe;
  wire  [NREG*8-1:0] regs;
  wire  sda_line = sda_m & ~sda_oe;

  blkreg_slave #(.NUM_REGS(NREG)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int oe_bad = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [8];

  function automatic logic [7:0] dflt(int i);
    return 8'((92 + 37 * i) % 256);
  endfunction

  // R9 monitor: output enable may only move while raw SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_m) oe_bad++;
    prev_oe <= sda_oe;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic put_bit(logic b);
    sda_m = b; hold();
    scl_m = 1'b1; hold();
    scl_m = 1'b0;
  endtask

  task automatic put_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    ack = ~sda_line;
    scl_m = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hold();
      scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      v[i] = sda_line;
      repeat (H/2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = ~give_ack; hold();
    scl_m = 1'b1; hold();
    chk("R9 released during master ack clock", sda_oe, 0);
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic cmp_regs(string req);
    for (int i = 0; i < NREG; i++) chk(req, regs[i*8 +: 8], model[i]);
  endtask

  task automatic blk_write(int idx, int cnt, int n, string req);
    logic a;
    int p;
    bus_start();
    put_byte(8'hD4, a); chk("R2 write address ack", a, 1);
    put_byte(8'(idx), a); chk({req, " index ack"}, a, 1);
    put_byte(8'(cnt), a); chk({req, " count ack"}, a, 1);
    p = idx % NREG;
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], a); chk({req, " data ack"}, a, 1);
      model[p] = wbuf[k];
      p = (p + 1) % NREG;
    end
    bus_stop();
    cmp_regs(req);
  endtask

  task automatic blk_read(int idx, int n, int exp_cnt, string req);
    logic a;
    logic [7:0] v;
    bus_start();
    put_byte(8'hD4, a); chk("R2 write address ack", a, 1);
    put_byte(8'(idx), a); chk({req, " index ack"}, a, 1);
    bus_start();
    put_byte(8'hD5, a); chk("R6 read address ack", a, 1);
    get_byte(v, n > 0); chk("R10 count byte returned", v, exp_cnt);
    for (int k = 0; k < n; k++) begin
      get_byte(v, k < n - 1);
      chk({req, " read data"}, v, model[(idx % NREG + k) % NREG]);
    end
    repeat (H) @(negedge clk);
    chk("R7 SDA released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) model[i] = dflt(i);
    cmp_regs("R1 reset default");
    chk("R1 SDA released after reset", sda_oe, 0);
  endtask

  task automatic t_read_defaults();
    blk_read(2, 3, NREG, "R6");
  endtask

  task automatic t_write_basic();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    blk_write(1, 3, 3, "R3");
    blk_read(1, 3, 3, "R3");
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'hA7; wbuf[1] = 8'hB8;
    blk_write(NREG - 1, 2, 2, "R5 wrap past last");
    wbuf[0] = 8'hC9;
    blk_write(NREG + 2, 1, 1, "R5 index modulo");
    blk_read(NREG - 1, 3, 1, "R5 read wrap");
  endtask

  task automatic t_past_count();
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    blk_write(3, 1, 3, "R4 data beyond count");
    blk_read(3, 1, 1, "R4");
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    put_byte(8'hD6, a); chk("R2 foreign address nack", a, 0);
    put_byte(8'h00, a); chk("R2 ignored after nack", a, 0);
    put_byte(8'h05, a); chk("R2 ignored after nack", a, 0);
    put_byte(8'hEE, a); chk("R2 ignored after nack", a, 0);
    bus_stop();
    cmp_regs("R2 bank untouched");
  endtask

  task automatic t_partial_stop();
    logic a;
    bus_start();
    put_byte(8'hD4, a);
    put_byte(8'h00, a);
    put_byte(8'h02, a);
    put_byte(8'h5A, a); chk("R8 full byte ack", a, 1);
    model[0] = 8'h5A;
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    cmp_regs("R8 partial byte dropped");
  endtask

  task automatic t_start_mid();
    logic a;
    logic [7:0] v;
    bus_start();
    put_byte(8'hD4, a);
    put_byte(8'h04, a);
    put_byte(8'h02, a);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    put_byte(8'hD5, a); chk("R11 restart address ack", a, 1);
    get_byte(v, 1'b0); chk("R11 count after restart", v, 2);
    bus_stop();
    cmp_regs("R11 aborted byte not written");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_read_defaults();
    t_write_basic();
    t_wrap();
    t_past_count();
    t_wrong_addr();
    t_partial_stop();
    t_start_mid();
    chk("R9 SDA changed while SCL high", oe_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule